// File: doc/BRIEF.md
# Rectangular Texture Tile Loader

The block copies a rectangle of texels out of byte-addressed system memory into a texture memory that is organised as 64-bit words. A single start pulse carries the whole command: the upper-left corner and the bottom edge in 10.2 fixed point, the source image pitch and base address, the texel size code, the first destination 64-bit word and the destination row length in 64-bit words. The loader walks the rectangle one row at a time. Each row is fetched as 32-bit big-endian words over a ready/valid read port, shifted back into alignment when the row starts at a byte offset that is not a multiple of four, byte-reversed, and written out as 32-bit halves of destination words.

Rows alternate between a straight copy and a swizzled copy. Every odd row exchanges the 32-bit halves of each 64-bit word, or the 64-bit halves of each 128-bit group when texels are 32 bits wide. Every destination row is filled in full from the source, so padding past the useful texels holds whatever source bytes follow. Before any memory traffic the loader checks that both the source span and the destination span fit their memories, and aborts the whole load if either does not.

Top module: `tile_loader`

## Requirements
- R1: The row count is ((lr_t_i - ul_t_i) >> 2) + 1. Each row writes 2*line_i 32-bit words, or 4*line_i when size_i is 3 (32-bit texels); every word of the row is written from source data, padding included.
- R2: Row 0 starts at source byte base_i + (ul_t_i>>2)*pitch_i + (((ul_s_i>>2) << size_i) >> 1); each following row starts pitch_i bytes later. Destination row r starts at 32-bit word index 2*dst_word_i + r*(row word count).
- R3: When a row starts at byte offset m = start[1:0] other than 0, one extra word is read first and each written word is (previous << 8m) | (next >> 8(4-m)), i.e. the four source bytes from the row start address onward, in big-endian order.
- R4: A written word carries the lowest-addressed of its four source bytes in wr_data_o[7:0] and the highest-addressed in wr_data_o[31:24].
- R5: In odd rows (row index bit 0 set) the k-th word of the row goes to row offset k XOR 1, or k XOR 2 when size_i is 3; even rows use offset k.
- R6: The load is aborted with no read and no write, ending with done_o and error_o high together, if the source end (row 0 start + rows*row bytes) exceeds the source memory size, if the destination end (2*dst_word_i + rows*row words) exceeds 2*TMEM_WORDS, if line_i is 0, or if lr_t_i < ul_t_i. A span that ends exactly at a limit is accepted.
- R7: Read addresses are 4-byte aligned; rd_addr_o is held stable while rd_valid_o waits for rd_ready_i, and one word is taken per cycle in which both are high.
- R8: busy_o is high from the cycle after an accepted start until the load ends; done_o pulses for one cycle at the end, and error_o pulses only together with done_o.
- R9: After reset busy_o, done_o, error_o, rd_valid_o and wr_en_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; command inputs are sampled with it |
| ul_s_i | input | CRD_W | Left edge, 10.2 fixed point |
| ul_t_i | input | CRD_W | Top edge, 10.2 fixed point |
| lr_t_i | input | CRD_W | Bottom edge, 10.2 fixed point |
| pitch_i | input | PITCH_W | Source image pitch in bytes |
| base_i | input | ADDR_W | Source image base byte address |
| size_i | input | 2 | Texel size code: 0=4, 1=8, 2=16, 3=32 bits |
| dst_word_i | input | log2(TMEM_WORDS) | First destination 64-bit word |
| line_i | input | LINE_W | Destination row length in 64-bit words |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read byte address, word aligned |
| rd_ready_i | input | 1 | Read accepted; rd_data_i valid in the same cycle |
| rd_data_i | input | 32 | Big-endian source word |
| wr_en_o | output | 1 | Texture memory write strobe |
| wr_addr_o | output | log2(TMEM_WORDS)+1 | Destination 32-bit word index |
| wr_data_o | output | 32 | Destination data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle end-of-load pulse |
| error_o | output | 1 | Abort flag, pulses with done_o |

## Verification
The bench builds the loader with a 12-bit source address (4 KB) and a 64-word texture memory while keeping the default coordinate, pitch and line widths. The small memories put both abort limits within a few short loads, so exact-fit and one-past spans on the source side and on the destination side are each exercised. An odd pitch and varied left edges make successive rows start at every byte offset, and a read port that stalls on a fixed pattern tests address holding across waits.

// File: rtl/tile_loader_pkg.sv
package tile_loader_pkg;
  typedef enum logic {ST_IDLE, ST_FETCH} tl_state_e;
  localparam logic [1:0] SZ_4  = 2'd0;
  localparam logic [1:0] SZ_8  = 2'd1;
  localparam logic [1:0] SZ_16 = 2'd2;
  localparam logic [1:0] SZ_32 = 2'd3;
endpackage

// File: rtl/tl_setup.sv
module tl_setup import tile_loader_pkg::*; #(
  parameter int CRD_W      = 12,
  parameter int PITCH_W    = 12,
  parameter int ADDR_W     = 16,
  parameter int LINE_W     = 9,
  parameter int TMEM_WORDS = 512,
  parameter int EXT_W      = ADDR_W + CRD_W + PITCH_W,
  localparam int DST_W     = $clog2(TMEM_WORDS),
  localparam int WA_W      = DST_W + 1,
  localparam int ROW_W     = CRD_W - 1,
  localparam int RW_W      = LINE_W + 2
) (
  input  logic [CRD_W-1:0]   ul_s_i,
  input  logic [CRD_W-1:0]   ul_t_i,
  input  logic [CRD_W-1:0]   lr_t_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [1:0]         size_i,
  input  logic [DST_W-1:0]   dst_word_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [EXT_W-1:0]   src_start_o,
  output logic [ROW_W-1:0]   rows_o,
  output logic [RW_W-1:0]    row_words_o,
  output logic [WA_W-1:0]    dst_start_o,
  output logic               abort_o
);
  localparam logic [EXT_W-1:0] SRC_LIMIT = EXT_W'(1) << ADDR_W;
  localparam logic [EXT_W-1:0] DST_LIMIT = EXT_W'(2 * TMEM_WORDS);

  logic [CRD_W-3:0] s0, t0;
  logic [CRD_W-1:0] span;
  logic [EXT_W-1:0] byte_off, src_end, dst_end, total_words;

  assign s0   = ul_s_i[CRD_W-1:2];
  assign t0   = ul_t_i[CRD_W-1:2];
  assign span = lr_t_i - ul_t_i;

  always_comb begin
    rows_o      = ROW_W'(span[CRD_W-1:2]) + ROW_W'(1);
    row_words_o = (size_i == SZ_32) ? {line_i, 2'b00} : {1'b0, line_i, 1'b0};
    byte_off    = (EXT_W'(s0) << size_i) >> 1;
    src_start_o = EXT_W'(base_i) + EXT_W'(t0) * EXT_W'(pitch_i) + byte_off;
    total_words = EXT_W'(rows_o) * EXT_W'(row_words_o);
    src_end     = src_start_o + (total_words << 2);
    dst_start_o = {dst_word_i, 1'b0};
    dst_end     = EXT_W'(dst_start_o) + total_words;
    abort_o     = (lr_t_i < ul_t_i) || (line_i == '0) ||
                  (src_end > SRC_LIMIT) || (dst_end > DST_LIMIT);
  end
endmodule

// File: rtl/tl_realign.sv
module tl_realign (
  input  logic [31:0] prev_i,
  input  logic [31:0] next_i,
  input  logic [1:0]  ofs_i,
  output logic [31:0] word_o
);
  logic [5:0] lsh, rsh;
  assign lsh = {1'b0, ofs_i, 3'b000};
  assign rsh = 6'd32 - lsh;

  always_comb begin
    if (ofs_i == 2'd0) word_o = next_i;
    else               word_o = (prev_i << lsh) | (next_i >> rsh);
  end
endmodule

// File: rtl/tl_byterev.sv
module tl_byterev #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] din_i,
  output logic [8*BYTES-1:0] dout_o
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign dout_o[8*i +: 8] = din_i[8*(BYTES-1-i) +: 8];
  end
endmodule

// File: rtl/tile_loader.sv
module tile_loader import tile_loader_pkg::*; #(
  parameter int CRD_W      = 12,
  parameter int PITCH_W    = 12,
  parameter int ADDR_W     = 16,
  parameter int LINE_W     = 9,
  parameter int TMEM_WORDS = 512,
  localparam int DST_W     = $clog2(TMEM_WORDS),
  localparam int WA_W      = DST_W + 1,
  localparam int ROW_W     = CRD_W - 1,
  localparam int RW_W      = LINE_W + 2,
  localparam int EXT_W     = ADDR_W + CRD_W + PITCH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CRD_W-1:0]   ul_s_i,
  input  logic [CRD_W-1:0]   ul_t_i,
  input  logic [CRD_W-1:0]   lr_t_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [1:0]         size_i,
  input  logic [DST_W-1:0]   dst_word_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic               rd_valid_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ready_i,
  input  logic [31:0]        rd_data_i,
  output logic               wr_en_o,
  output logic [WA_W-1:0]    wr_addr_o,
  output logic [31:0]        wr_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o
);
  tl_state_e         state;
  logic [EXT_W-1:0]  row_addr, row_addr_nxt, src_start;
  logic [ADDR_W-1:0] rd_ptr;
  logic [WA_W-1:0]   dst_row, dst_start;
  logic [ROW_W-1:0]  rows_left, rows;
  logic [RW_W-1:0]   row_words, row_words_c, k, swz;
  logic [PITCH_W-1:0] pitch_q;
  logic              odd_row, wide, have_prev, abort;
  logic [31:0]       prev, aligned, swapped;
  logic [1:0]        ofs;

  tl_setup #(
    .CRD_W(CRD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W),
    .LINE_W(LINE_W), .TMEM_WORDS(TMEM_WORDS), .EXT_W(EXT_W)
  ) i_setup (
    .ul_s_i, .ul_t_i, .lr_t_i, .pitch_i, .base_i, .size_i,
    .dst_word_i, .line_i,
    .src_start_o (src_start),
    .rows_o      (rows),
    .row_words_o (row_words_c),
    .dst_start_o (dst_start),
    .abort_o     (abort)
  );

  assign ofs = row_addr[1:0];

  tl_realign i_realign (
    .prev_i (prev),
    .next_i (rd_data_i),
    .ofs_i  (ofs),
    .word_o (aligned)
  );

  tl_byterev #(.BYTES(4)) i_byterev (
    .din_i  (aligned),
    .dout_o (swapped)
  );

  assign row_addr_nxt = row_addr + EXT_W'(pitch_q);
  assign swz          = odd_row ? (wide ? RW_W'(2) : RW_W'(1)) : '0;
  assign rd_valid_o   = (state == ST_FETCH);
  assign rd_addr_o    = rd_ptr;
  assign busy_o       = (state != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      row_addr  <= '0;
      rd_ptr    <= '0;
      dst_row   <= '0;
      rows_left <= '0;
      row_words <= '0;
      k         <= '0;
      pitch_q   <= '0;
      odd_row   <= 1'b0;
      wide      <= 1'b0;
      have_prev <= 1'b0;
      prev      <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (abort) begin
              done_o  <= 1'b1;
              error_o <= 1'b1;
            end else begin
              state     <= ST_FETCH;
              row_addr  <= src_start;
              rd_ptr    <= {src_start[ADDR_W-1:2], 2'b00};
              dst_row   <= dst_start;
              rows_left <= rows;
              row_words <= row_words_c;
              pitch_q   <= pitch_i;
              wide      <= (size_i == SZ_32);
              odd_row   <= 1'b0;
              k         <= '0;
              have_prev <= 1'b0;
            end
          end
        end
        ST_FETCH: begin
          if (rd_ready_i) begin
            rd_ptr <= rd_ptr + ADDR_W'(4);
            prev   <= rd_data_i;
            if (ofs != 2'd0 && !have_prev) begin
              // priming read: first word only feeds the shifter
              have_prev <= 1'b1;
            end else begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= dst_row + WA_W'(k ^ swz);
              wr_data_o <= swapped;
              if (k == row_words - RW_W'(1)) begin
                if (rows_left == ROW_W'(1)) begin
                  state  <= ST_IDLE;
                  done_o <= 1'b1;
                end else begin
                  rows_left <= rows_left - ROW_W'(1);
                  odd_row   <= ~odd_row;
                  row_addr  <= row_addr_nxt;
                  rd_ptr    <= {row_addr_nxt[ADDR_W-1:2], 2'b00};
                  dst_row   <= dst_row + WA_W'(row_words);
                  k         <= '0;
                  have_prev <= 1'b0;
                end
              end else begin
                k <= k + RW_W'(1);
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_loader_chk.sv
module tile_loader_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              wr_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o
);
  a_r7_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  a_r7_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_addr_o[1:0] == 2'b00);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_error_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  a_r8_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o || done_o);

  a_r6_abort_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !wr_en_o && !rd_valid_o);
endmodule

bind tile_loader tile_loader_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .rd_addr_o  (rd_addr_o),
  .wr_en_o    (wr_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o)
);

// File: tb/test_tile_loader.sv
`timescale 1ns/1ps
module test_tile_loader;
  localparam int CRD_W = 12, PITCH_W = 12, ADDR_W = 12, LINE_W = 9, TMEM_WORDS = 64;
  localparam int DST_W = $clog2(TMEM_WORDS), WA_W = DST_W + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CRD_W-1:0] ul_s = 0, ul_t = 0, lr_t = 0;
  logic [PITCH_W-1:0] pitch = 0;
  logic [ADDR_W-1:0] base = 0;
  logic [1:0] size = 0;
  logic [DST_W-1:0] dst_word = 0;
  logic [LINE_W-1:0] line = 0;
  logic rd_valid, rd_ready = 0, wr_en, busy, done, error;
  logic [ADDR_W-1:0] rd_addr;
  logic [31:0] rd_data, wr_data;
  logic [WA_W-1:0] wr_addr;

  int n_chk = 0, n_fail = 0, rd_seen = 0;
  logic [2:0] st_cnt = 0;
  bit stall_en = 0;
  logic [WA_W-1:0] exp_a[$];
  logic [31:0] exp_d[$];
  string exp_tag[$];

  always #4 clk = ~clk;

  function automatic logic [7:0] byte_at(int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h3c);
  endfunction

  assign rd_data = {byte_at(int'(rd_addr)), byte_at(int'(rd_addr) + 1),
                    byte_at(int'(rd_addr) + 2), byte_at(int'(rd_addr) + 3)};

  tile_loader #(.CRD_W(CRD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W),
                .LINE_W(LINE_W), .TMEM_WORDS(TMEM_WORDS)) i_tile_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ul_s_i(ul_s), .ul_t_i(ul_t), .lr_t_i(lr_t), .pitch_i(pitch),
    .base_i(base), .size_i(size), .dst_word_i(dst_word), .line_i(line),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done), .error_o(error));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // read port stall pattern and read counter
  always @(negedge clk) begin
    st_cnt <= st_cnt + 3'd1;
    rd_ready <= stall_en ? (st_cnt != 3'd2 && st_cnt != 3'd5) : 1'b1;
    if (rst_n && rd_valid) rd_seen <= rd_seen + 1;
  end

  // monitor: pop and compare each write
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_a.size() == 0) begin
        chk(0, "R6", "unexpected write addr", longint'(wr_addr), 0);
      end else begin
        logic [WA_W-1:0] ea;
        logic [31:0] ed;
        string tg;
        ea = exp_a.pop_front(); ed = exp_d.pop_front(); tg = exp_tag.pop_front();
        chk(wr_addr == ea, tg, "write address", longint'(wr_addr), longint'(ea));
        chk(wr_data == ed, (tg == "R2") ? "R4" : tg, "write data",
            longint'(wr_data), longint'(ed));
      end
    end
  end

  task automatic run_load(int uls, int ult, int lrt, int pch, int bse, int sz,
                          int dwd, int ln, bit exp_err);
    if (!exp_err) begin
      int rows = ((lrt - ult) >> 2) + 1;
      int rw = ln * 2 * ((sz == 3) ? 2 : 1);
      int st = bse + (ult >> 2) * pch + (((uls >> 2) << sz) >> 1);
      for (int r = 0; r < rows; r++) begin
        int ra = st + r * pch;
        for (int k = 0; k < rw; k++) begin
          int a = ra + 4 * k;
          int sw = (r % 2 == 1) ? ((sz == 3) ? 2 : 1) : 0;
          exp_a.push_back(WA_W'(dwd * 2 + r * rw + (k ^ sw)));
          exp_d.push_back({byte_at(a + 3), byte_at(a + 2), byte_at(a + 1), byte_at(a)});
          exp_tag.push_back((r % 2 == 1) ? "R5" : ((ra % 4) != 0) ? "R3" : "R2");
        end
      end
    end
    @(negedge clk);
    rd_seen = 0;
    ul_s = CRD_W'(uls); ul_t = CRD_W'(ult); lr_t = CRD_W'(lrt);
    pitch = PITCH_W'(pch); base = ADDR_W'(bse); size = 2'(sz);
    dst_word = DST_W'(dwd); line = LINE_W'(ln); start = 1;
    @(negedge clk);
    start = 0;
    if (!exp_err) chk(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    begin
      int n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(n < 5000, "R8", "done seen", n, 0);
    end
    chk(error == exp_err, "R6", "error flag at done", longint'(error), longint'(exp_err));
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", longint'(done), 0);
    chk(busy == 1'b0, "R8", "idle after done", longint'(busy), 0);
    chk(exp_a.size() == 0, "R1", "writes left outstanding", exp_a.size(), 0);
    if (exp_err) chk(rd_seen == 0, "R6", "reads on abort", rd_seen, 0);
    exp_a.delete(); exp_d.delete(); exp_tag.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({busy, done, error, rd_valid, wr_en} == 5'b0, "R9", "outputs in reset",
        longint'({busy, done, error, rd_valid, wr_en}), 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, error, rd_valid, wr_en} == 5'b0, "R9", "outputs after reset",
        longint'({busy, done, error, rd_valid, wr_en}), 0);

    // R1 R2 R3: 16-bit, offset 2, fractional bottom edge gives 3 rows
    run_load(12, 8, 19, 64, 'h100, 2, 5, 2, 0);
    // R3 R5: 8-bit, odd pitch walks every byte offset
    stall_en = 1;
    run_load(20, 0, 12, 13, 'h40, 1, 0, 3, 0);
    // R5: 32-bit texels, 64-bit half swap in odd rows, offset 3
    run_load(4, 4, 12, 40, 'h203, 3, 8, 2, 0);
    // R2 R4: 4-bit texels, half-byte column addressing
    run_load(28, 0, 7, 20, 'h0, 0, 20, 1, 0);
    stall_en = 0;
    // R2: fully aligned copy
    run_load(0, 0, 4, 32, 'h400, 2, 30, 4, 0);
    // R6: destination exactly full, then one word past
    run_load(0, 0, 4, 16, 'h80, 2, 60, 2, 0);
    run_load(0, 0, 4, 16, 'h80, 2, 61, 2, 1);
    // R6: source exactly at end, then past end
    run_load(0, 0, 4, 16, 4096 - 32, 2, 0, 2, 0);
    run_load(0, 0, 4, 16, 4096 - 20, 2, 0, 2, 1);
    // R6: zero line length and inverted rows
    run_load(0, 0, 4, 16, 'h80, 2, 0, 0, 1);
    run_load(0, 8, 4, 16, 'h80, 2, 0, 2, 1);
    finish_sim();
  end
endmodule